// File: doc/BRIEF.md
# Compressed-Code Direct Branch Target Generator

This block computes the target of a direct branch for a processor that fetches compressed instructions. Compressed instructions start at any bit position inside a 32-bit memory word. A compressed address therefore has two parts: a 28-bit word base address in the upper bits and a 4-bit in-word bit position in the low bits.

For each issued branch, the block receives the displacement field, an absolute/relative flag, a conditional/unconditional flag and the compressed address of the branch. The low four bits of the displacement are the target's bit position. They go straight to the output and never pass through the adder. The bits above them form a signed word displacement: 20 bits for unconditional branches and 10 bits for conditional ones. In absolute mode this word displacement, sign-extended, is the target word address. In relative mode it is added to the word base address of the branch.

The inputs are accepted on a valid strobe. The registered target and its valid flag appear one clock later.

Top module: `cbt_target_gen`

## Requirements
- R1: The target's bit position `tgt_addr[3:0]` equals `disp_i[3:0]` of the accepted branch. The bit-position field `br_addr_i[3:0]` of the branch has no effect on the target.
- R2: Unconditional absolute (`is_cond_i`=0, `is_abs_i`=1): `tgt_addr[31:4]` is `disp_i[23:4]` sign-extended from bit 23 to 28 bits.
- R3: Conditional absolute (`is_cond_i`=1, `is_abs_i`=1): `tgt_addr[31:4]` is `disp_i[13:4]` sign-extended from bit 13 to 28 bits. For conditional branches, `disp_i[23:14]` has no effect.
- R4: Unconditional relative (`is_cond_i`=0, `is_abs_i`=0): `tgt_addr[31:4]` = `br_addr_i[31:4]` + sign-extended `disp_i[23:4]`.
- R5: Conditional relative (`is_cond_i`=1, `is_abs_i`=0): `tgt_addr[31:4]` = `br_addr_i[31:4]` + sign-extended `disp_i[13:4]`.
- R6: The relative-mode sum wraps modulo 2^28. No overflow indication exists.
- R7: `tgt_valid` is 1 in the cycle after a clock edge where `in_valid` was 1, and 0 after an edge where `in_valid` was 0.
- R8: `tgt_addr` keeps its previous value across edges where `in_valid` is 0.
- R9: A synchronous active-high `rst` clears `tgt_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Branch inputs are valid this cycle |
| is_abs_i | input | 1 | 1 = absolute addressing, 0 = relative |
| is_cond_i | input | 1 | 1 = conditional (14-bit field), 0 = unconditional (24-bit field) |
| disp_i | input | 24 | Displacement field; conditional branches use bits 13:0 |
| br_addr_i | input | 32 | Compressed address of the branch (word base in 31:4, bit position in 3:0) |
| tgt_valid | output | 1 | Target address valid |
| tgt_addr | output | 32 | Compressed target address (word base in 31:4, bit position in 3:0) |

## Verification
The vector table covers all four mode/type combinations. For each branch type it uses the most positive and the most negative word displacements, which confirms sign extension from the correct bit. Bit positions 0 and 15 confirm that the low nibble bypasses the arithmetic. The relative vectors use branch addresses with a non-zero bit position, a negative offset and a sum that crosses 2^28, which separates correct wrap and word-only addition from byte-style arithmetic. Further cases put junk in the upper displacement bits of conditional branches, leave gaps in the strobe to test hold and valid timing, and apply reset.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int ADDR_W = 32;
  localparam int IP_W   = 4;
  localparam int WB_W   = ADDR_W - IP_W;
  localparam int UNC_W  = 24;
  localparam int CND_W  = 14;

  typedef struct packed {
    logic [WB_W-1:0] word;
    logic [IP_W-1:0] ip;
  } caddr_t;
endpackage

// File: rtl/cbt_disp_split.sv
module cbt_disp_split #(
  parameter int DISP_W = 24,
  parameter int IP_W   = 4,
  parameter int WB_W   = 28
) (
  input  logic [DISP_W-1:0] disp,
  output logic [IP_W-1:0]   ip,
  output logic [WB_W-1:0]   woff
);
  localparam int WD_W  = DISP_W - IP_W;
  localparam int EXT_W = WB_W - WD_W;

  logic [WD_W-1:0] wdisp;

  always_comb begin
    ip    = disp[IP_W-1:0];
    wdisp = disp[DISP_W-1:IP_W];
    woff  = {{EXT_W{wdisp[WD_W-1]}}, wdisp};
  end
endmodule

// File: rtl/cbt_word_base.sv
module cbt_word_base #(
  parameter int WB_W = 28
) (
  input  logic            is_abs,
  input  logic [WB_W-1:0] br_word,
  input  logic [WB_W-1:0] woff,
  output logic [WB_W-1:0] tgt_word
);
  logic [WB_W-1:0] rel_sum;

  always_comb begin
    rel_sum  = br_word + woff;
    tgt_word = is_abs ? woff : rel_sum;
  end
endmodule

// File: rtl/cbt_target_gen.sv
module cbt_target_gen
  import cbt_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_IP_W   = IP_W,
  parameter int P_UNC_W  = UNC_W,
  parameter int P_CND_W  = CND_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                is_abs_i,
  input  logic                is_cond_i,
  input  logic [P_UNC_W-1:0]  disp_i,
  input  logic [P_ADDR_W-1:0] br_addr_i,
  output logic                tgt_valid,
  output logic [P_ADDR_W-1:0] tgt_addr
);
  localparam int L_WB_W = P_ADDR_W - P_IP_W;

  logic [P_IP_W-1:0] ip_unc, ip_cnd, ip_sel;
  logic [L_WB_W-1:0] off_unc, off_cnd, off_sel;
  logic [L_WB_W-1:0] word_nxt;
  logic [P_ADDR_W-1:0] addr_q;
  logic                valid_q;

  cbt_disp_split #(.DISP_W(P_UNC_W), .IP_W(P_IP_W), .WB_W(L_WB_W)) u_split_unc (
    .disp (disp_i),
    .ip   (ip_unc),
    .woff (off_unc)
  );

  cbt_disp_split #(.DISP_W(P_CND_W), .IP_W(P_IP_W), .WB_W(L_WB_W)) u_split_cnd (
    .disp (disp_i[P_CND_W-1:0]),
    .ip   (ip_cnd),
    .woff (off_cnd)
  );

  always_comb begin
    ip_sel  = is_cond_i ? ip_cnd  : ip_unc;
    off_sel = is_cond_i ? off_cnd : off_unc;
  end

  cbt_word_base #(.WB_W(L_WB_W)) u_base (
    .is_abs   (is_abs_i),
    .br_word  (br_addr_i[P_ADDR_W-1:P_IP_W]),
    .woff     (off_sel),
    .tgt_word (word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= in_valid;
    if (in_valid) addr_q <= {word_nxt, ip_sel};
  end

  assign tgt_valid = valid_q;
  assign tgt_addr  = addr_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !tgt_valid); // R9
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> tgt_valid); // R7
  AST_IDLE_NOVALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !tgt_valid); // R7
  AST_IP_BYPASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> tgt_addr[P_IP_W-1:0] == $past(disp_i[P_IP_W-1:0])); // R1
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(tgt_addr)); // R8
  AST_UNC_ABS_LOW: assert property (@(posedge clk) disable iff (rst)
    in_valid && is_abs_i && !is_cond_i |=>
      tgt_addr[P_UNC_W-1:P_IP_W] == $past(disp_i[P_UNC_W-1:P_IP_W])); // R2
  AST_CND_ABS_LOW: assert property (@(posedge clk) disable iff (rst)
    in_valid && is_abs_i && is_cond_i |=>
      tgt_addr[P_CND_W-1:P_IP_W] == $past(disp_i[P_CND_W-1:P_IP_W])); // R3
  AST_REL_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    in_valid && !is_abs_i && !is_cond_i && disp_i[P_UNC_W-1:P_IP_W] == '0 |=>
      tgt_addr[P_ADDR_W-1:P_IP_W] == $past(br_addr_i[P_ADDR_W-1:P_IP_W])); // R4
endmodule

// File: tb/cbt_target_gen_tb.sv
module cbt_target_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        is_abs_i;
  logic        is_cond_i;
  logic [23:0] disp_i;
  logic [31:0] br_addr_i;
  logic        tgt_valid;
  logic [31:0] tgt_addr;

  int total = 0;
  int bad   = 0;

  always #10ns clk = ~clk;

  cbt_target_gen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .is_abs_i(is_abs_i),
    .is_cond_i(is_cond_i), .disp_i(disp_i), .br_addr_i(br_addr_i),
    .tgt_valid(tgt_valid), .tgt_addr(tgt_addr)
  );

  // {cond, abs, disp[23:0], branch addr[31:0], expected target[31:0]}
  localparam int NV = 13;
  localparam logic [89:0] VEC [NV] = '{
    {1'b0, 1'b1, 24'h000015, 32'h00000000, 32'h00000015},
    {1'b0, 1'b1, 24'h7FFFFF, 32'h12345678, 32'h007FFFFF},
    {1'b0, 1'b1, 24'h800000, 32'h00000000, 32'hFF800000},
    {1'b0, 1'b0, 24'h000020, 32'h00001238, 32'h00001250},
    {1'b0, 1'b0, 24'hFFFFF3, 32'h10000000, 32'h0FFFFFF3},
    {1'b0, 1'b0, 24'h00001F, 32'hFFFFFFF0, 32'h0000000F},
    {1'b0, 1'b0, 24'h7FFFF0, 32'h00000000, 32'h007FFFF0},
    {1'b1, 1'b1, 24'h001FF7, 32'h00000000, 32'h00001FF7},
    {1'b1, 1'b1, 24'h002000, 32'h00000000, 32'hFFFFE000},
    {1'b1, 1'b1, 24'hABC015, 32'h00000000, 32'h00000015},
    {1'b1, 1'b0, 24'h003FFF, 32'h00400000, 32'h003FFFFF},
    {1'b1, 1'b0, 24'h00001F, 32'h0000010C, 32'h0000011F},
    {1'b1, 1'b0, 24'hFC2000, 32'h00000005, 32'hFFFFE000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic c, input logic a,
                       input logic [23:0] d, input logic [31:0] b);
    in_valid = v; is_cond_i = c; is_abs_i = a; disp_i = d; br_addr_i = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; is_abs_i = 1'b0; is_cond_i = 1'b0;
    disp_i = '0; br_addr_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 valid after reset", {31'b0, tgt_valid}, 32'h0);
    rst = 1'b0;

    // Vector table: each row is applied, then checked after one edge.
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic c, a;
      c = VEC[i][89];
      a = VEC[i][88];
      tag = c ? (a ? "R3" : "R5") : (a ? "R2" : "R4");
      if (i == 5 || i == 12) tag = {tag, "/R6 wrap"};
      drive(1'b1, c, a, VEC[i][87:64], VEC[i][63:32]);
      check(tag, tgt_addr, VEC[i][31:0]);
      check("R1 ip field", {28'b0, tgt_addr[3:0]}, {28'b0, VEC[i][67:64]});
      check("R7 valid after strobe", {31'b0, tgt_valid}, 32'h1);
    end

    // R8: no strobe, new inputs must not disturb the held target
    drive(1'b0, 1'b0, 1'b1, 24'h123456, 32'hDEADBEEF);
    check("R7 idle valid", {31'b0, tgt_valid}, 32'h0);
    check("R8 hold", tgt_addr, 32'hFFFFE000);
    drive(1'b0, 1'b1, 1'b0, 24'h000000, 32'h00000000);
    check("R8 hold second gap", tgt_addr, 32'hFFFFE000);

    // R1: branch bit position must not leak into target
    drive(1'b1, 1'b0, 1'b0, 24'h000000, 32'h0000ABCF);
    check("R1 branch ip ignored", tgt_addr, 32'h0000ABC0);

    // R9: reset during a strobe clears valid
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 24'h000010, 32'h0);
    check("R9 reset with strobe", {31'b0, tgt_valid}, 32'h0);
    rst = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 24'h00200F, 32'h0);
    check("R3 after reset", tgt_addr, 32'hFFFFE00F);
    check("R7 after reset", {31'b0, tgt_valid}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule